// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss for a 32-bit virtual address. When the translation buffer misses, the requester hands the walker the faulting virtual address. The walker then reads the table hierarchy in memory, one level at a time. It starts from a per-process directory base register. It reads one directory entry, checks that entry's valid bit, and then reads one entry from the second-level table that the directory entry points to. The second-level entry supplies the physical page number that goes back to the buffer refill logic.

Both reads go straight to a memory read port that does not pass through the translation buffer. Each read is a one-cycle request with an address. The answer is a one-cycle response that arrives after any number of wait cycles. The faulting access stays stalled for the whole walk. The walk ends in one of two ways: a one-cycle completion strobe that carries the page number and the assembled physical address, or a one-cycle fault strobe when either level holds an entry that is not valid.

Top module: `ptw_walker`

## Requirements
- R1: After synchronous reset, the walker is idle: `miss_ready` is 1, and `mem_req`, `walk_done` and `walk_fault` are 0.
- R2: The cycle after a miss is accepted, the walker issues exactly one read with address = base + VA[31:22]*4. Here base is the directory base register.
- R3: A directory entry whose bit 0 (the valid bit) is 0 ends the walk with a one-cycle `walk_fault`. No second read is issued and `walk_done` stays low.
- R4: A valid directory entry leads to a second read. Its address = {entry[31:12], 12'h000} + VA[21:12]*4. Entry bits 11..1 are ignored.
- R5: A valid second-level entry ends the walk with a one-cycle `walk_done`. `walk_ppn` = entry[31:12] and `walk_pa` = {entry[31:12], VA[11:0]}.
- R6: A second-level entry whose bit 0 is 0 ends the walk with a one-cycle `walk_fault` and no `walk_done`.
- R7: A miss is accepted only while `miss_ready` is 1, which holds only when the walker is idle. A `miss_valid` held high during a walk changes neither that walk's addresses nor its result.
- R8: Each read request lasts one cycle. No new request is issued while a read is outstanding. Any number of wait cycles before `mem_rvalid` is tolerated.
- R9: A pulse on `base_load` loads `base_data` into the directory base register. Walks that start afterwards index from the new base.
- R10: `walk_done` and `walk_fault` are never high together. The walker is idle again in the cycle after either strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_load | input | 1 | Load strobe for the directory base register |
| base_data | input | 32 | Physical address of the directory |
| miss_valid | input | 1 | Translation miss request |
| miss_va | input | 32 | Faulting virtual address |
| miss_ready | output | 1 | Walker idle; a miss is accepted this cycle |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Read address, valid with `mem_req` |
| mem_rvalid | input | 1 | One-cycle read response strobe |
| mem_rdata | input | 32 | Read response data |
| walk_done | output | 1 | One-cycle completion strobe |
| walk_fault | output | 1 | One-cycle fault strobe |
| walk_ppn | output | 20 | Physical page number, valid with `walk_done` |
| walk_pa | output | 32 | Translated physical address, valid with `walk_done` |

## Verification
Two kinds of state error show up at the ports within a single walk. A captured index or frame field that is corrupted appears in the address of the very next read request. A wrong state transition appears as a missing or extra request, or as a strobe raised for the wrong outcome, no later than a few cycles after the response that should have ended the walk. The sweep runs every directory index, with valid and invalid entries at both levels, varying response latency, a base reload part way through, and miss requests held high during walks. As a result, a fault on any branch surfaces as a wrong address, a wrong request count or a wrong strobe.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    parameter int VA_W      = 32;
    parameter int PA_W      = 32;
    parameter int DIR_IDX_W = 10;
    parameter int PT_IDX_W  = 10;
    parameter int OFF_W     = 12;
    parameter int ENT_BYTES = 4;

    localparam int PN_W      = PA_W - OFF_W;
    localparam int ENT_SHIFT = $clog2(ENT_BYTES);
    localparam int RSVD_W    = OFF_W - 1;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_DIR_REQ  = 3'd1,
        ST_DIR_WAIT = 3'd2,
        ST_TBL_REQ  = 3'd3,
        ST_TBL_WAIT = 3'd4,
        ST_FINISH   = 3'd5
    } walk_state_t;

    typedef struct packed {
        logic [PN_W-1:0]   frame;
        logic [RSVD_W-1:0] rsvd;
        logic              present;
    } tbl_entry_t;

    typedef struct packed {
        logic [DIR_IDX_W-1:0] dir_idx;
        logic [PT_IDX_W-1:0]  tbl_idx;
        logic [OFF_W-1:0]     offset;
    } vaddr_t;

    function automatic logic [PA_W-1:0] slot_addr(
        input logic [PA_W-1:0] table_base,
        input logic [DIR_IDX_W-1:0] slot
    );
        logic [PA_W-1:0] scaled;
        scaled = PA_W'(slot) << ENT_SHIFT;
        return table_base + scaled;
    endfunction

endpackage

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
    import ptw_pkg::*;
(
    input  logic [PA_W-1:0] raw,
    output logic            present,
    output logic [PN_W-1:0] frame
);
    tbl_entry_t ent;
    logic       unused_rsvd_bits;

    always_comb begin
        ent     = tbl_entry_t'(raw);
        present = ent.present;
        frame   = ent.frame;
    end

    assign unused_rsvd_bits = ^ent.rsvd;
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic                 second_level,
    input  logic [PA_W-1:0]      dir_base,
    input  logic [PN_W-1:0]      tbl_frame,
    input  logic [DIR_IDX_W-1:0] dir_idx,
    input  logic [PT_IDX_W-1:0]  tbl_idx,
    output logic [PA_W-1:0]      rd_addr
);
    logic [PA_W-1:0] tbl_base;

    always_comb begin
        tbl_base = {tbl_frame, {OFF_W{1'b0}}};
        if (second_level)
            rd_addr = slot_addr(tbl_base, DIR_IDX_W'(tbl_idx));
        else
            rd_addr = slot_addr(dir_base, dir_idx);
    end
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        resp_valid,
    input  logic        resp_present,
    output walk_state_t state,
    output logic        take_dir,
    output logic        take_tbl,
    output logic        issue,
    output logic        idle
);
    walk_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_DIR_REQ;
            ST_DIR_REQ:  state_d = ST_DIR_WAIT;
            ST_DIR_WAIT: if (resp_valid) state_d = resp_present ? ST_TBL_REQ : ST_FINISH;
            ST_TBL_REQ:  state_d = ST_TBL_WAIT;
            ST_TBL_WAIT: if (resp_valid) state_d = ST_FINISH;
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state    = state_q;
    assign take_dir = (state_q == ST_DIR_WAIT) && resp_valid;
    assign take_tbl = (state_q == ST_TBL_WAIT) && resp_valid;
    assign issue    = (state_q == ST_DIR_REQ) || (state_q == ST_TBL_REQ);
    assign idle     = (state_q == ST_IDLE);
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            base_load,
    input  logic [PA_W-1:0] base_data,
    input  logic            miss_valid,
    input  logic [VA_W-1:0] miss_va,
    output logic            miss_ready,
    output logic            mem_req,
    output logic [PA_W-1:0] mem_addr,
    input  logic            mem_rvalid,
    input  logic [PA_W-1:0] mem_rdata,
    output logic            walk_done,
    output logic            walk_fault,
    output logic [PN_W-1:0] walk_ppn,
    output logic [PA_W-1:0] walk_pa
);
    walk_state_t     state;
    logic            take_dir, take_tbl, issue, idle;
    logic            ent_present;
    logic [PN_W-1:0] ent_frame;

    logic [PA_W-1:0] base_q;
    vaddr_t          va_q;
    logic [PN_W-1:0] frame_q;
    logic [PN_W-1:0] ppn_q;
    logic            ok_q;

    ptw_entry_decode dec_i (
        .raw     (mem_rdata),
        .present (ent_present),
        .frame   (ent_frame)
    );

    ptw_fsm fsm_i (
        .clk          (clk),
        .rst          (rst),
        .start        (miss_valid),
        .resp_valid   (mem_rvalid),
        .resp_present (ent_present),
        .state        (state),
        .take_dir     (take_dir),
        .take_tbl     (take_tbl),
        .issue        (issue),
        .idle         (idle)
    );

    ptw_addr_gen agen_i (
        .second_level (state == ST_TBL_REQ),
        .dir_base     (base_q),
        .tbl_frame    (frame_q),
        .dir_idx      (va_q.dir_idx),
        .tbl_idx      (va_q.tbl_idx),
        .rd_addr      (mem_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else if (base_load) begin
            base_q <= base_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            va_q    <= '0;
            frame_q <= '0;
            ppn_q   <= '0;
            ok_q    <= 1'b0;
        end else begin
            if (idle && miss_valid) begin
                va_q <= vaddr_t'(miss_va);
                ok_q <= 1'b0;
            end
            if (take_dir) begin
                frame_q <= ent_frame;
                ok_q    <= 1'b0;
            end
            if (take_tbl) begin
                ppn_q <= ent_frame;
                ok_q  <= ent_present;
            end
        end
    end

    assign miss_ready = idle;
    assign mem_req    = issue;
    assign walk_done  = (state == ST_FINISH) && ok_q;
    assign walk_fault = (state == ST_FINISH) && !ok_q;
    assign walk_ppn   = ppn_q;
    assign walk_pa    = {ppn_q, va_q.offset};
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
    input logic clk,
    input logic rst,
    input logic miss_valid,
    input logic miss_ready,
    input logic mem_req,
    input logic mem_rvalid,
    input logic walk_done,
    input logic walk_fault
);
    logic pending;

    always_ff @(posedge clk) begin
        if (rst)             pending <= 1'b0;
        else if (mem_req)    pending <= 1'b1;
        else if (mem_rvalid) pending <= 1'b0;
    end

    // R8: request is a single-cycle pulse
    a_r8_req_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R8: never a second read while one is outstanding
    a_r8_one_outstanding: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !pending);

    // R10: the two end strobes are exclusive
    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(walk_done && walk_fault));

    // R10: done is one cycle, then idle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        walk_done |=> (!walk_done && miss_ready));

    // R10: fault is one cycle, then idle
    a_r10_fault_pulse: assert property (@(posedge clk) disable iff (rst)
        walk_fault |=> (!walk_fault && miss_ready));

    // R7: an idle walker issues nothing and signals nothing
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        miss_ready |-> (!mem_req && !walk_done && !walk_fault));

    // R7: an accepted miss leaves the idle state
    a_r7_accept: assert property (@(posedge clk) disable iff (rst)
        (miss_ready && miss_valid) |=> !miss_ready);

    // R2: accepted miss issues the directory read next cycle
    a_r2_dir_read: assert property (@(posedge clk) disable iff (rst)
        (miss_ready && miss_valid) |=> mem_req);

    // R5: a walk ends only after a memory response
    a_r5_end_after_resp: assert property (@(posedge clk) disable iff (rst)
        (walk_done || walk_fault) |-> ($past(mem_rvalid) && !pending));
endmodule

bind ptw_walker ptw_walker_chk chk_i (.*);

// File: tb/ptw_walker_tb_top.sv
module ptw_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        base_load = 1'b0;
    logic [31:0] base_data = '0;
    logic        miss_valid = 1'b0;
    logic [31:0] miss_va = '0;
    logic        miss_ready;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        walk_done;
    logic        walk_fault;
    logic [19:0] walk_ppn;
    logic [31:0] walk_pa;

    int          checks = 0;
    int          errors = 0;
    bit          finished = 0;
    int          req_cnt = 0;
    logic [31:0] addr1, addr2;
    logic [31:0] cur_base = '0;

    always #2.5 clk = ~clk;

    ptw_walker dut_i (
        .clk(clk), .rst(rst), .base_load(base_load), .base_data(base_data),
        .miss_valid(miss_valid), .miss_va(miss_va), .miss_ready(miss_ready),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .walk_done(walk_done), .walk_fault(walk_fault),
        .walk_ppn(walk_ppn), .walk_pa(walk_pa)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] dir_word(input int idx);
        logic [19:0] frame;
        frame = 20'h80000 + 20'(idx * 3);
        return {frame, 11'h555, ((idx % 7) != 3)};
    endfunction

    function automatic logic [31:0] tbl_word(input logic [31:0] a);
        logic [31:0] w;
        logic [19:0] pn;
        w  = a >> 2;
        pn = 20'((w * 32'd2654435) ^ 32'h3C3C3);
        return {pn, 11'h2AA, ((w % 11) != 5)};
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        if (a >= cur_base && a < cur_base + 32'd4096)
            return dir_word(int'((a - cur_base) >> 2));
        return tbl_word(a);
    endfunction

    // memory responder with address-dependent latency (R8)
    initial begin
        forever begin
            @(negedge clk);
            while (mem_req) begin
                logic [31:0] a;
                int lat;
                a = mem_addr;
                req_cnt++;
                if (req_cnt == 1) addr1 = a; else addr2 = a;
                lat = int'((a[7:2] ^ a[15:10]) % 4);
                repeat (lat + 1) @(negedge clk);
                mem_rvalid = 1'b1;
                mem_rdata  = mem_word(a);
                @(negedge clk);
                mem_rvalid = 1'b0;
                mem_rdata  = '0;
            end
        end
    end

    task automatic load_base(input logic [31:0] b);
        base_load = 1'b1;
        base_data = b;
        @(negedge clk);
        base_load = 1'b0;
        cur_base  = b;
    endtask

    task automatic run_walk(input int di, input int pi, input int off, input bit inject);
        logic [31:0] va, d, t, a2;
        bit exp_fault;
        int n;
        va = {di[9:0], pi[9:0], off[11:0]};
        req_cnt = 0;
        check(miss_ready === 1'b1, "R7 ready before walk", 32'(miss_ready), 32'd1);
        miss_valid = 1'b1;
        miss_va    = va;
        @(negedge clk);
        check(miss_ready === 1'b0, "R7 not ready during walk", 32'(miss_ready), 32'd0);
        if (inject) miss_va = ~va;
        else miss_valid = 1'b0;
        n = 0;
        while (!(walk_done || walk_fault) && n < 64) begin
            @(negedge clk);
            n++;
        end
        miss_valid = 1'b0;

        d = dir_word(di);
        exp_fault = 0;
        check(addr1 === cur_base + 32'(di * 4), "R2 dir address", addr1, cur_base + 32'(di * 4));
        if (!d[0]) begin
            exp_fault = 1;
            check(req_cnt == 1, "R3 single read on bad dir entry", 32'(req_cnt), 32'd1);
            check(walk_fault === 1'b1 && walk_done === 1'b0, "R3 fault on bad dir entry",
                  {30'd0, walk_done, walk_fault}, 32'd1);
        end else begin
            a2 = {d[31:12], 12'h000} + 32'(pi * 4);
            t  = tbl_word(a2);
            check(req_cnt == 2, "R4 two reads", 32'(req_cnt), 32'd2);
            check(addr2 === a2, "R4 table address", addr2, a2);
            if (t[0]) begin
                check(walk_done === 1'b1 && walk_fault === 1'b0, "R5 done strobe",
                      {30'd0, walk_done, walk_fault}, 32'd2);
                check(walk_ppn === t[31:12], "R5 ppn", 32'(walk_ppn), 32'(t[31:12]));
                check(walk_pa === {t[31:12], off[11:0]}, "R5 pa", walk_pa, {t[31:12], off[11:0]});
            end else begin
                exp_fault = 1;
                check(walk_fault === 1'b1 && walk_done === 1'b0, "R6 fault on bad table entry",
                      {30'd0, walk_done, walk_fault}, 32'd1);
            end
        end
        if (inject)
            check(addr1 === cur_base + 32'(di * 4), "R7 held miss ignored", addr1, cur_base + 32'(di * 4));
        @(negedge clk);
        check(!walk_done && !walk_fault && miss_ready, "R10 one-cycle strobe then idle",
              {29'd0, miss_ready, walk_done, walk_fault}, 32'd4);
        check(req_cnt == (exp_fault && !d[0] ? 1 : 2), "R8 no extra requests",
              32'(req_cnt), (exp_fault && !d[0]) ? 32'd1 : 32'd2);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        check(miss_ready === 1'b1 && mem_req === 1'b0 && walk_done === 1'b0 && walk_fault === 1'b0,
              "R1 reset state", {28'd0, miss_ready, mem_req, walk_done, walk_fault}, 32'h8);
        rst = 1'b0;
        @(negedge clk);
        check(miss_ready === 1'b1 && mem_req === 1'b0, "R1 idle after reset",
              {30'd0, miss_ready, mem_req}, 32'd2);

        for (int k = 0; k < 1024; k++) begin
            if (k % 256 == 0) begin
                load_base(32'h0004_0000 * (k / 256 + 1) + 32'h1000 * (k / 256));
                if (k != 0) begin
                    run_walk(1, 5, 7, 1'b0);
                    check(addr1 === cur_base + 32'd4, "R9 new base used", addr1, cur_base + 32'd4);
                end
            end
            run_walk(k, (k * 37 + 11) % 1024, (k * 291) % 4096, (k % 5) == 2);
        end
        // boundary table indices and offsets
        run_walk(1, 1023, 4095, 1'b0);
        run_walk(1, 0, 0, 1'b0);
        run_walk(1023, 1023, 4095, 1'b1);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule